// File: doc/BRIEF.md
# L2 Registry Directory Controller

This block is the shared second-level controller for a group of private first-level caches. It keeps one entry per word. An entry holds either the word's current value or the id of the core that has registered the word as its own. A single flag per entry tells the two cases apart, so the same array serves as both data store and directory. The directory never keeps a list of sharers, and caches may pass copies among themselves without telling it.

Each core can present a read or a register request. A fixed-priority arbiter grants one request per cycle, and the lowest core id wins. A read of an unregistered word is answered with data. A read of a registered word is forwarded to the owner, which then supplies the data directly to the requester. A register request is acknowledged. If another core held the word, that core is sent a revoke. A separate write-back port carries revoke replies and evictions from the owners. The returned value is kept only if the sender still owns the word.

Top module: `l2reg_top`

## Requirements
- R1: In every cycle with at least one request, `reqGrant` is one-hot and selects the lowest-numbered requesting core. With no request, `reqGrant` is zero. The grant is combinational in the same cycle.
- R2: A granted read (`reqIsReg`=0) of an unregistered word gives, one cycle later, `rspValid`=1, `rspKind`=0 (data), `rspDest` equal to the requester, and `rspData` equal to the stored word.
- R3: A granted read of a registered word gives, one cycle later, `rspKind`=1 (forward), `rspDest` equal to the owner and `rspReq` equal to the requester. The entry is left unchanged.
- R4: A granted register request (`reqIsReg`=1) gives `rspKind`=2 (acknowledge) to the requester one cycle later. The requester becomes the owner, so later reads are forwarded to it.
- R5: A register request for a word owned by a different core also raises `rvkValid` in the same cycle as the acknowledge. `rvkCore` is set to the previous owner and `rvkAddr` to the word.
- R6: A register request from the current owner is acknowledged and raises no revoke.
- R7: A write-back from the current owner turns the entry back into data. A later read then returns the written value.
- R8: A write-back from a core that is not the owner, or to an unregistered word, is ignored.
- R9: When a register request and a write-back target the same word in the same cycle, the registration wins and the write-back is dropped.
- R10: After reset, no response or revoke is presented, every word is unregistered, and every word reads as zero.
- R11: A cycle with no request yields `rspValid`=0 and `rvkValid`=0 in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | NCORE | Request present, one bit per core |
| reqIsReg | input | NCORE | 1 = register request, 0 = read, per core |
| reqAddr | input | NCORE*AW | Word address per core, core i at bits [i*AW +: AW] |
| reqGrant | output | NCORE | One-hot grant of the accepted request |
| wbValid | input | 1 | Write-back (revoke reply or eviction) present |
| wbCore | input | CW | Core sending the write-back |
| wbAddr | input | AW | Word written back |
| wbData | input | DW | Value written back |
| rspValid | output | 1 | Response message valid |
| rspKind | output | 2 | 0 data, 1 forward, 2 acknowledge |
| rspDest | output | CW | Core the response is sent to |
| rspReq | output | CW | Original requester |
| rspAddr | output | AW | Word address of the response |
| rspData | output | DW | Word value for data responses, zero otherwise |
| rvkValid | output | 1 | Revoke message valid |
| rvkCore | output | CW | Core losing its registration |
| rvkAddr | output | AW | Word revoked |

## Verification
The grant is combinational, so the bench checks it after driving inputs and before the next rising edge. The response and revoke buses pass through one register, so each is checked one time unit after the rising edge that accepts the request. Entry updates made at that edge, such as ownership changes and accepted write-backs, become visible only to requests granted in later cycles. The bench therefore checks them by issuing later reads and comparing the kind, destination and data of those reads against its own word-by-word model.

// File: rtl/l2reg_pkg.sv
package l2reg_pkg;

  typedef enum logic [1:0] {
    RSP_DATA = 2'd0,
    RSP_FWD  = 2'd1,
    RSP_ACK  = 2'd2
  } rspKind_e;

  // Strobes from control to datapath for the accepted request of this cycle
  typedef struct packed {
    logic     rspValid;
    rspKind_e kind;
    logic     sendRvk;
    logic     setReg;
    logic     takeWb;
  } strobes_t;

endpackage

// File: rtl/l2reg_ctrl.sv
module l2reg_ctrl
  import l2reg_pkg::*;
#(
  parameter int NCORE = 4,
  parameter int AW    = 6,
  parameter int CW    = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NCORE-1:0]    reqValid,
  input  logic [NCORE-1:0]    reqIsReg,
  input  logic [NCORE*AW-1:0] reqAddr,
  input  logic                wbValid,
  input  logic [CW-1:0]       wbCore,
  input  logic [AW-1:0]       wbAddr,
  input  logic                curRegd,
  input  logic [CW-1:0]       curOwner,
  input  logic                wbRegd,
  input  logic [CW-1:0]       wbOwner,
  output logic [NCORE-1:0]    grant,
  output logic [CW-1:0]       selCore,
  output logic [AW-1:0]       selAddr,
  output strobes_t            stb
);

  logic [NCORE:0] lowerAny;
  logic           selIsReg;
  logic           anyReq;

  assign lowerAny[0] = 1'b0;

  // Priority chain: a core is granted when no lower id is requesting
  for (genvar i = 0; i < NCORE; i++) begin : g_arb
    assign grant[i]      = reqValid[i] & ~lowerAny[i];
    assign lowerAny[i+1] = lowerAny[i] | reqValid[i];
  end

  assign anyReq = lowerAny[NCORE];

  always_comb begin
    selCore  = '0;
    selAddr  = '0;
    selIsReg = 1'b0;
    for (int i = 0; i < NCORE; i++) begin
      if (grant[i]) begin
        selCore  = CW'(i);
        selAddr  = reqAddr[i*AW +: AW];
        selIsReg = reqIsReg[i];
      end
    end
  end

  always_comb begin
    stb          = '0;
    stb.rspValid = anyReq;
    if (selIsReg)     stb.kind = RSP_ACK;
    else if (curRegd) stb.kind = RSP_FWD;
    else              stb.kind = RSP_DATA;
    stb.setReg  = anyReq & selIsReg;
    stb.sendRvk = anyReq & selIsReg & curRegd & (curOwner != selCore);
    stb.takeWb  = wbValid & wbRegd & (wbOwner == wbCore)
                & ~(anyReq & selIsReg & (selAddr == wbAddr));
  end

  // R1
  grant_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(grant));

  // R1
  grant_lowest_chk: assert property (@(posedge clk) disable iff (!rstN)
    (grant != '0) |-> (((grant & reqValid) == grant) &&
                       ((reqValid & (grant - 1'b1)) == '0)));

  // R1
  grant_any_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid != '0) |-> (grant != '0));

endmodule

// File: rtl/l2reg_dp.sv
module l2reg_dp
  import l2reg_pkg::*;
#(
  parameter int WORDS = 64,
  parameter int DW    = 32,
  parameter int AW    = 6,
  parameter int CW    = 2
) (
  input  logic          clk,
  input  logic          rstN,
  input  strobes_t      stb,
  input  logic [CW-1:0] selCore,
  input  logic [AW-1:0] selAddr,
  input  logic [AW-1:0] wbAddr,
  input  logic [DW-1:0] wbData,
  output logic          curRegd,
  output logic [CW-1:0] curOwner,
  output logic          wbRegd,
  output logic [CW-1:0] wbOwner,
  output logic          rspValid,
  output rspKind_e      rspKind,
  output logic [CW-1:0] rspDest,
  output logic [CW-1:0] rspReq,
  output logic [AW-1:0] rspAddr,
  output logic [DW-1:0] rspData,
  output logic          rvkValid,
  output logic [CW-1:0] rvkCore,
  output logic [AW-1:0] rvkAddr
);

  logic [DW-1:0]    store [WORDS];
  logic [WORDS-1:0] regd;

  assign curRegd  = regd[selAddr];
  assign curOwner = store[selAddr][CW-1:0];
  assign wbRegd   = regd[wbAddr];
  assign wbOwner  = store[wbAddr][CW-1:0];

  // Entry update; control guarantees the two writes never share a word
  always_ff @(posedge clk) begin
    if (!rstN) begin
      regd <= '0;
      for (int w = 0; w < WORDS; w++) store[w] <= '0;
    end else begin
      if (stb.takeWb) begin
        store[wbAddr] <= wbData;
        regd[wbAddr]  <= 1'b0;
      end
      if (stb.setReg) begin
        store[selAddr] <= {{(DW-CW){1'b0}}, selCore};
        regd[selAddr]  <= 1'b1;
      end
    end
  end

  // Outgoing message registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspKind  <= RSP_DATA;
      rspDest  <= '0;
      rspReq   <= '0;
      rspAddr  <= '0;
      rspData  <= '0;
      rvkValid <= 1'b0;
      rvkCore  <= '0;
      rvkAddr  <= '0;
    end else begin
      rspValid <= stb.rspValid;
      rspKind  <= stb.kind;
      rspDest  <= (stb.kind == RSP_FWD) ? curOwner : selCore;
      rspReq   <= selCore;
      rspAddr  <= selAddr;
      rspData  <= (stb.kind == RSP_DATA) ? store[selAddr] : '0;
      rvkValid <= stb.sendRvk;
      rvkCore  <= curOwner;
      rvkAddr  <= selAddr;
    end
  end

  // R5
  rvk_with_ack_chk: assert property (@(posedge clk) disable iff (!rstN)
    rvkValid |-> (rspValid && rspKind == RSP_ACK && rvkAddr == rspAddr));

  // R6
  rvk_not_self_chk: assert property (@(posedge clk) disable iff (!rstN)
    rvkValid |-> (rvkCore != rspDest));

endmodule

// File: rtl/l2reg_top.sv
module l2reg_top
  import l2reg_pkg::*;
#(
  parameter int NCORE = 4,
  parameter int WORDS = 64,
  parameter int DW    = 32,
  localparam int AW   = $clog2(WORDS),
  localparam int CW   = $clog2(NCORE)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NCORE-1:0]    reqValid,
  input  logic [NCORE-1:0]    reqIsReg,
  input  logic [NCORE*AW-1:0] reqAddr,
  output logic [NCORE-1:0]    reqGrant,
  input  logic                wbValid,
  input  logic [CW-1:0]       wbCore,
  input  logic [AW-1:0]       wbAddr,
  input  logic [DW-1:0]       wbData,
  output logic                rspValid,
  output logic [1:0]          rspKind,
  output logic [CW-1:0]       rspDest,
  output logic [CW-1:0]       rspReq,
  output logic [AW-1:0]       rspAddr,
  output logic [DW-1:0]       rspData,
  output logic                rvkValid,
  output logic [CW-1:0]       rvkCore,
  output logic [AW-1:0]       rvkAddr
);

  strobes_t      stb;
  logic [CW-1:0] selCore;
  logic [AW-1:0] selAddr;
  logic          curRegd;
  logic [CW-1:0] curOwner;
  logic          wbRegd;
  logic [CW-1:0] wbOwner;
  rspKind_e      kindQ;

  l2reg_ctrl #(.NCORE(NCORE), .AW(AW), .CW(CW)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .reqValid(reqValid), .reqIsReg(reqIsReg), .reqAddr(reqAddr),
    .wbValid(wbValid), .wbCore(wbCore), .wbAddr(wbAddr),
    .curRegd(curRegd), .curOwner(curOwner),
    .wbRegd(wbRegd), .wbOwner(wbOwner),
    .grant(reqGrant), .selCore(selCore), .selAddr(selAddr), .stb(stb)
  );

  l2reg_dp #(.WORDS(WORDS), .DW(DW), .AW(AW), .CW(CW)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb),
    .selCore(selCore), .selAddr(selAddr),
    .wbAddr(wbAddr), .wbData(wbData),
    .curRegd(curRegd), .curOwner(curOwner),
    .wbRegd(wbRegd), .wbOwner(wbOwner),
    .rspValid(rspValid), .rspKind(kindQ), .rspDest(rspDest),
    .rspReq(rspReq), .rspAddr(rspAddr), .rspData(rspData),
    .rvkValid(rvkValid), .rvkCore(rvkCore), .rvkAddr(rvkAddr)
  );

  assign rspKind = kindQ;

  // R11
  no_rsp_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid == '0) |=> (!rspValid && !rvkValid));

endmodule

// File: tb/l2reg_top_bench.sv
`timescale 1ns/1ps
module l2reg_top_bench;

  localparam int N  = 4;
  localparam int W  = 64;
  localparam int DW = 32;
  localparam int AW = 6;
  localparam int CW = 2;

  logic          clk = 1'b0;
  logic          rstN;
  logic [N-1:0]  reqValid;
  logic [N-1:0]  reqIsReg;
  logic [N*AW-1:0] reqAddr;
  logic [N-1:0]  reqGrant;
  logic          wbValid;
  logic [CW-1:0] wbCore;
  logic [AW-1:0] wbAddr;
  logic [DW-1:0] wbData;
  logic          rspValid;
  logic [1:0]    rspKind;
  logic [CW-1:0] rspDest, rspReq, rvkCore;
  logic [AW-1:0] rspAddr, rvkAddr;
  logic [DW-1:0] rspData;
  logic          rvkValid;

  int checks = 0;
  int fails  = 0;

  // Reference model
  bit           mRegd [W];
  logic [CW-1:0] mOwn [W];
  logic [DW-1:0] mVal [W];

  always #2 clk = ~clk;

  l2reg_top u_l2reg_top (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqIsReg(reqIsReg),
    .reqAddr(reqAddr), .reqGrant(reqGrant), .wbValid(wbValid),
    .wbCore(wbCore), .wbAddr(wbAddr), .wbData(wbData),
    .rspValid(rspValid), .rspKind(rspKind), .rspDest(rspDest),
    .rspReq(rspReq), .rspAddr(rspAddr), .rspData(rspData),
    .rvkValid(rvkValid), .rvkCore(rvkCore), .rvkAddr(rvkAddr)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [N-1:0] expGrant(input logic [N-1:0] v);
    for (int i = 0; i < N; i++) if (v[i]) return N'(1) << i;
    return '0;
  endfunction

  // One cycle: drive, check grant, predict, clock, check registered outputs
  task automatic step(input logic [N-1:0] v, input logic [N-1:0] r,
                      input logic [N*AW-1:0] a, input logic wv,
                      input logic [CW-1:0] wc, input logic [AW-1:0] wa,
                      input logic [DW-1:0] wd, input string tag);
    logic [N-1:0] g;
    int win;
    logic [AW-1:0] sa;
    bit eV, eRvk, isR;
    logic [1:0] eKind;
    logic [CW-1:0] eDest, eRvkCore;
    logic [DW-1:0] eData;
    string t;
    @(negedge clk);
    reqValid = v; reqIsReg = r; reqAddr = a;
    wbValid = wv; wbCore = wc; wbAddr = wa; wbData = wd;
    #1;
    g = expGrant(v);
    chk(reqGrant == g, "R1 grant", 32'(reqGrant), 32'(g));
    win = -1;
    for (int i = N - 1; i >= 0; i--) if (v[i]) win = i;
    eV = (win >= 0); eRvk = 1'b0; eKind = 2'd0; eDest = '0; eData = '0;
    eRvkCore = '0; sa = '0; isR = 1'b0; t = tag;
    if (eV) begin
      sa  = a[win*AW +: AW];
      isR = r[win];
      if (isR) begin
        eKind = 2'd2; eDest = CW'(win);
        eRvk = mRegd[sa] && (mOwn[sa] != CW'(win));
        eRvkCore = mOwn[sa];
        if (t == "") t = eRvk ? "R5" : (mRegd[sa] ? "R6" : "R4");
      end else if (mRegd[sa]) begin
        eKind = 2'd1; eDest = mOwn[sa];
        if (t == "") t = "R3";
      end else begin
        eKind = 2'd0; eDest = CW'(win); eData = mVal[sa];
        if (t == "") t = "R2";
      end
    end else if (t == "") t = "R11";
    if (wv && mRegd[wa] && mOwn[wa] == wc && !(eV && isR && sa == wa)) begin
      mRegd[wa] = 1'b0; mVal[wa] = wd;
    end
    if (eV && isR) begin
      mRegd[sa] = 1'b1; mOwn[sa] = CW'(win);
    end
    @(posedge clk); #1;
    chk(rspValid == eV, {t, " rspValid"}, 32'(rspValid), 32'(eV));
    chk(rvkValid == eRvk, {t, " rvkValid"}, 32'(rvkValid), 32'(eRvk));
    if (eV) begin
      chk(rspKind == eKind, {t, " rspKind"}, 32'(rspKind), 32'(eKind));
      chk(rspDest == eDest, {t, " rspDest"}, 32'(rspDest), 32'(eDest));
      chk(rspReq == CW'(win), {t, " rspReq"}, 32'(rspReq), 32'(win));
      chk(rspAddr == sa, {t, " rspAddr"}, 32'(rspAddr), 32'(sa));
      if (eKind == 2'd0)
        chk(rspData == eData, {t, " rspData"}, rspData, eData);
    end
    if (eRvk) begin
      chk(rvkCore == eRvkCore, {t, " rvkCore"}, 32'(rvkCore), 32'(eRvkCore));
      chk(rvkAddr == sa, {t, " rvkAddr"}, 32'(rvkAddr), 32'(sa));
    end
  endtask

  function automatic logic [N*AW-1:0] one(input int core, input int adr);
    logic [N*AW-1:0] f = '0;
    f[core*AW +: AW] = AW'(adr);
    return f;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [N*AW-1:0] aa;
    logic [CW-1:0] wc;
    logic [AW-1:0] wa;
    void'($urandom(32'd2024));
    for (int w = 0; w < W; w++) begin
      mRegd[w] = 1'b0; mOwn[w] = '0; mVal[w] = '0;
    end
    rstN = 1'b0; reqValid = '0; reqIsReg = '0; reqAddr = '0;
    wbValid = 1'b0; wbCore = '0; wbAddr = '0; wbData = '0;
    repeat (3) @(posedge clk);
    #1;
    chk(rspValid == 1'b0, "R10 rspValid in reset", 32'(rspValid), 0);
    chk(rvkValid == 1'b0, "R10 rvkValid in reset", 32'(rvkValid), 0);
    @(negedge clk); rstN = 1'b1;

    // R10: fresh word reads as zero data
    step(4'b1000, 4'b0000, one(3, 9), 0, 0, 0, 0, "R10");
    chk(rspData == '0, "R10 zero data", rspData, 0);
    step(4'b0010, 4'b0010, one(1, 9), 0, 0, 0, 0, "R4");      // core1 owns 9
    step(4'b0001, 4'b0000, one(0, 9), 0, 0, 0, 0, "R3");      // forward to 1
    step(4'b0100, 4'b0100, one(2, 9), 0, 0, 0, 0, "R5");      // revoke core1
    step(4'b0100, 4'b0100, one(2, 9), 0, 0, 0, 0, "R6");      // owner again
    step(4'b0000, 4'b0000, '0, 1, 2'd1, 6'd9, 32'hAAAA, "R11"); // stale wb
    step(4'b0001, 4'b0000, one(0, 9), 0, 0, 0, 0, "R8");      // still fwd to 2
    step(4'b0000, 4'b0000, '0, 1, 2'd3, 6'd12, 32'hBEEF, "R8"); // unregistered
    step(4'b0001, 4'b0000, one(0, 12), 0, 0, 0, 0, "R8");
    step(4'b0000, 4'b0000, '0, 1, 2'd2, 6'd9, 32'h1234, "R11");
    step(4'b1000, 4'b0000, one(3, 9), 0, 0, 0, 0, "R7");      // data 1234
    aa = one(0, 1) | one(1, 2) | one(2, 3) | one(3, 4);
    step(4'b1111, 4'b0000, aa, 0, 0, 0, 0, "R1");
    step(4'b1100, 4'b0000, aa, 0, 0, 0, 0, "R1");
    step(4'b0010, 4'b0010, one(1, 20), 0, 0, 0, 0, "R4");
    step(4'b0100, 4'b0100, one(2, 20), 1, 2'd1, 6'd20, 32'h55, "R9");
    step(4'b0001, 4'b0000, one(0, 20), 0, 0, 0, 0, "R9");     // fwd to 2

    // Constrained random traffic on a small hot address range
    for (int n = 0; n < 4000; n++) begin
      aa = '0;
      for (int i = 0; i < N; i++)
        aa[i*AW +: AW] = ($urandom % 4 == 0) ? AW'($urandom) : AW'($urandom % 8);
      wa = AW'($urandom % 8);
      wc = CW'($urandom);
      if (mRegd[wa] && ($urandom % 4 != 0)) wc = mOwn[wa];
      step(N'($urandom), N'($urandom), aa, 1'($urandom), wc, wa, $urandom, "");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule